// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block holds the pending interrupt flags of a small CPU and runs the hardware part of taking an interrupt. Each of 32 priority levels has one flag. Level 31 is reset. Levels 28 to 30 are non-maskable: a pin NMI, an oscillator fault and a flash access violation. Levels 27 and below are maskable. Among them are a comparator at 27, a watchdog interval at 26, a timer channel-0 compare at 25, a combined timer vector at 24, an ADC at 21, a serial unit at 20, and two I/O ports at 19 and 18.

At an instruction boundary the block checks whether any flag is eligible, and if so it runs a fixed six-cycle entry. First it pushes the next-instruction program counter and then the status register, each one word lower on the stack. Next it selects the highest pending level and clears that flag when the vector has only one source. It then signals a status-register clear, which ends any low-power mode and drops the global enable. Finally it reads the vector word and hands it to the CPU as the new program counter, together with the new stack pointer.

The CPU datapath, the memory and the return from interrupt are outside the block and connect through the strobes below.

Top module: `irq_entry_seq`

## Requirements
- R1: An entry starts only in the cycle after `instrDone` is sampled high while at least one eligible flag is pending. Without `instrDone` no entry starts, however long a flag waits.
- R2: Once started, `busy` stays high for exactly six consecutive cycles and then returns low.
- R3: In cycle 1 the stack write port writes `pcIn` to address `spIn-2`. In cycle 2 it writes `srIn` to `spIn-4`. Both values are captured at the boundary, and `stkWrEn` is low in every other cycle.
- R4: The level taken is the highest eligible pending level. `ackLevel` shows this level from cycle 4 through cycle 6.
- R5: Levels below 28 are eligible only when bit 3 (global enable) of `srIn` is set. Levels 28 to 31 are eligible regardless of that bit, and a maskable flag that is refused stays pending.
- R6: When the taken level has a single source, its flag is cleared automatically. Levels 31, 30, 24, 20, 19 and 18 are multi-source: their flags stay set until `swClr` clears them.
- R7: `srClr` pulses for one cycle in cycle 4.
- R8: In cycle 5 `vecRdEn` is high with `vecRdAddr = 0xFFC0 + 2*level`, so level 31 reads 0xFFFE. In cycle 6 `pcLoad` and `spLoad` are high, `pcNew` equals the word read in cycle 5, and `spNew = spIn-4`.
- R9: A request that arrives during an entry is only latched. It takes no part in the current selection, and `instrDone` during an entry is ignored. The new request is taken at the next boundary after the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqSet | input | 32 | One-cycle set pulse per priority level |
| swClr | input | 32 | Software clear per priority level |
| instrDone | input | 1 | Instruction boundary strobe |
| srIn | input | 16 | Current status register; bit 3 is the global enable |
| pcIn | input | 16 | Address of the next instruction |
| spIn | input | 16 | Current stack pointer |
| vecRdData | input | 16 | Word returned for `vecRdAddr` in the same cycle |
| busy | output | 1 | High during the six entry cycles |
| stkWrEn | output | 1 | Stack write strobe |
| stkWrAddr | output | 16 | Stack write address |
| stkWrData | output | 16 | Stack write data |
| srClr | output | 1 | Clear the status register |
| vecRdEn | output | 1 | Vector read strobe |
| vecRdAddr | output | 16 | Vector word address |
| pcLoad | output | 1 | Load `pcNew` into the program counter |
| pcNew | output | 16 | Handler address |
| spLoad | output | 1 | Load `spNew` into the stack pointer |
| spNew | output | 16 | Stack pointer after both pushes |
| ackLevel | output | 5 | Level being taken |
| pendFlags | output | 32 | Pending flags |

## Verification
The assertions assume that the vector memory answers combinationally, so `vecRdData` is valid in the cycle of `vecRdEn`. They also assume that `instrDone` is a one-cycle strobe given only while the CPU is not inside an entry, apart from the deliberate overlap used for R9. The bench meets these assumptions with a combinational vector model, `vecRdAddr ^ 0x1234`. It raises `instrDone` for a single cycle at a time. Each flag is posted at least one edge before the boundary that should see it, and no stimulus enters the sequence except the one mid-sequence request that tests R9.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_PC = 3'd1,
    ST_PUSH_SR = 3'd2,
    ST_SELECT  = 3'd3,
    ST_CLR_SR  = 3'd4,
    ST_VEC_RD  = 3'd5,
    ST_LOAD_PC = 3'd6
  } seqState_e;

  // strobes from control to datapath, one per sequence step
  typedef struct packed {
    logic start;
    logic pushPc;
    logic pushSr;
    logic select;
    logic clrSr;
    logic vecRd;
    logic loadPc;
  } seqStrobe_t;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N_LVL = 32,
  localparam int unsigned LVL_W = $clog2(N_LVL)
) (
  input  logic [N_LVL-1:0] req,
  output logic             found,
  output logic [LVL_W-1:0] level
);

  // highest set index wins: later iterations override earlier ones
  always_comb begin
    found = 1'b0;
    level = '0;
    for (int i = 0; i < N_LVL; i++) begin
      if (req[i]) begin
        found = 1'b1;
        level = LVL_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrDone,
  input  logic       anyEligible,
  output seqStrobe_t strobe,
  output logic       busy
);

  seqState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:    if (instrDone && anyEligible) stateD = ST_PUSH_PC;
      ST_PUSH_PC: stateD = ST_PUSH_SR;
      ST_PUSH_SR: stateD = ST_SELECT;
      ST_SELECT:  stateD = ST_CLR_SR;
      ST_CLR_SR:  stateD = ST_VEC_RD;
      ST_VEC_RD:  stateD = ST_LOAD_PC;
      ST_LOAD_PC: stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe        = '0;
    strobe.start  = (stateQ == ST_IDLE) && instrDone && anyEligible;
    strobe.pushPc = (stateQ == ST_PUSH_PC);
    strobe.pushSr = (stateQ == ST_PUSH_SR);
    strobe.select = (stateQ == ST_SELECT);
    strobe.clrSr  = (stateQ == ST_CLR_SR);
    strobe.vecRd  = (stateQ == ST_VEC_RD);
    strobe.loadPc = (stateQ == ST_LOAD_PC);
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter int unsigned       N_LVL      = 32,
  parameter int unsigned       W          = 16,
  parameter int unsigned       NMI_LO     = 28,
  parameter int unsigned       GIE_BIT    = 3,
  parameter int unsigned       VEC_TOP    = 'hFFFE,
  parameter logic [N_LVL-1:0]  MULTI_MASK = 32'hC11C_0000,
  localparam int unsigned      LVL_W      = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [N_LVL-1:0] reqSet,
  input  logic [N_LVL-1:0] swClr,
  input  logic [W-1:0]     srIn,
  input  logic [W-1:0]     pcIn,
  input  logic [W-1:0]     spIn,
  input  logic [W-1:0]     vecRdData,
  output logic             anyEligible,
  output logic             stkWrEn,
  output logic [W-1:0]     stkWrAddr,
  output logic [W-1:0]     stkWrData,
  output logic             srClr,
  output logic             vecRdEn,
  output logic [W-1:0]     vecRdAddr,
  output logic             pcLoad,
  output logic [W-1:0]     pcNew,
  output logic             spLoad,
  output logic [W-1:0]     spNew,
  output logic [LVL_W-1:0] ackLevel,
  output logic [N_LVL-1:0] pendFlags
);

  localparam logic [W-1:0]     VEC_BASE    = W'(VEC_TOP - 2 * (N_LVL - 1));
  localparam logic [W-1:0]     WORD_BYTES  = W'(2);
  localparam logic [N_LVL-1:0] SINGLE_MASK = ~MULTI_MASK;

  function automatic logic [N_LVL-1:0] buildNmiMask();
    logic [N_LVL-1:0] m;
    for (int i = 0; i < N_LVL; i++) m[i] = (i >= NMI_LO);
    return m;
  endfunction

  localparam logic [N_LVL-1:0] NMI_MASK = buildNmiMask();

  logic [N_LVL-1:0] flagsQ, snapQ, eligible, autoClr;
  logic [W-1:0]     pcCapQ, srCapQ, spCapQ, vecQ;
  logic [LVL_W-1:0] selLvlQ, encLvl;
  logic             encFound;

  // maskable levels need the global enable, the rest pass always
  assign eligible    = flagsQ & (srIn[GIE_BIT] ? {N_LVL{1'b1}} : NMI_MASK);
  assign anyEligible = |eligible;

  // selection works on the snapshot taken at the boundary
  irq_prio_enc #(.N_LVL(N_LVL)) enc_i (
    .req   (snapQ),
    .found (encFound),
    .level (encLvl)
  );

  always_comb begin
    autoClr = '0;
    if (strobe.select && encFound) autoClr[encLvl] = SINGLE_MASK[encLvl];
  end

  // a new request wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= (flagsQ & ~swClr & ~autoClr) | reqSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapQ   <= '0;
      pcCapQ  <= '0;
      srCapQ  <= '0;
      spCapQ  <= '0;
      selLvlQ <= '0;
      vecQ    <= '0;
    end else begin
      if (strobe.start) begin
        snapQ  <= eligible;
        pcCapQ <= pcIn;
        srCapQ <= srIn;
        spCapQ <= spIn;
      end
      if (strobe.select) selLvlQ <= encLvl;
      if (strobe.vecRd)  vecQ    <= vecRdData;
    end
  end

  assign stkWrEn   = strobe.pushPc | strobe.pushSr;
  assign stkWrAddr = strobe.pushPc ? (spCapQ - WORD_BYTES) : (spCapQ - 2 * WORD_BYTES);
  assign stkWrData = strobe.pushPc ? pcCapQ : srCapQ;
  assign srClr     = strobe.clrSr;
  assign vecRdEn   = strobe.vecRd;
  assign vecRdAddr = VEC_BASE + W'({selLvlQ, 1'b0});
  assign pcLoad    = strobe.loadPc;
  assign pcNew     = vecQ;
  assign spLoad    = strobe.loadPc;
  assign spNew     = spCapQ - 2 * WORD_BYTES;
  assign ackLevel  = selLvlQ;
  assign pendFlags = flagsQ;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned      N_LVL      = 32,
  parameter int unsigned      W          = 16,
  parameter int unsigned      NMI_LO     = 28,
  parameter int unsigned      GIE_BIT    = 3,
  parameter int unsigned      VEC_TOP    = 'hFFFE,
  parameter logic [N_LVL-1:0] MULTI_MASK = 32'hC11C_0000,
  localparam int unsigned     LVL_W      = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N_LVL-1:0] reqSet,
  input  logic [N_LVL-1:0] swClr,
  input  logic             instrDone,
  input  logic [W-1:0]     srIn,
  input  logic [W-1:0]     pcIn,
  input  logic [W-1:0]     spIn,
  input  logic [W-1:0]     vecRdData,
  output logic             busy,
  output logic             stkWrEn,
  output logic [W-1:0]     stkWrAddr,
  output logic [W-1:0]     stkWrData,
  output logic             srClr,
  output logic             vecRdEn,
  output logic [W-1:0]     vecRdAddr,
  output logic             pcLoad,
  output logic [W-1:0]     pcNew,
  output logic             spLoad,
  output logic [W-1:0]     spNew,
  output logic [LVL_W-1:0] ackLevel,
  output logic [N_LVL-1:0] pendFlags
);

  seqStrobe_t strobe;
  logic       anyEligible;

  irq_seq_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .instrDone   (instrDone),
    .anyEligible (anyEligible),
    .strobe      (strobe),
    .busy        (busy)
  );

  irq_seq_dp #(
    .N_LVL      (N_LVL),
    .W          (W),
    .NMI_LO     (NMI_LO),
    .GIE_BIT    (GIE_BIT),
    .VEC_TOP    (VEC_TOP),
    .MULTI_MASK (MULTI_MASK)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqSet      (reqSet),
    .swClr       (swClr),
    .srIn        (srIn),
    .pcIn        (pcIn),
    .spIn        (spIn),
    .vecRdData   (vecRdData),
    .anyEligible (anyEligible),
    .stkWrEn     (stkWrEn),
    .stkWrAddr   (stkWrAddr),
    .stkWrData   (stkWrData),
    .srClr       (srClr),
    .vecRdEn     (vecRdEn),
    .vecRdAddr   (vecRdAddr),
    .pcLoad      (pcLoad),
    .pcNew       (pcNew),
    .spLoad      (spLoad),
    .spNew       (spNew),
    .ackLevel    (ackLevel),
    .pendFlags   (pendFlags)
  );

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         instrDone,
  input logic         busy,
  input logic         stkWrEn,
  input logic [W-1:0] stkWrAddr,
  input logic         srClr,
  input logic         vecRdEn,
  input logic [W-1:0] vecRdData,
  input logic         pcLoad,
  input logic [W-1:0] pcNew,
  input logic         spLoad
);

  // R1: an entry begins only right after a boundary strobe
  a_r1_start_after_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(instrDone));

  // R2: every sequence output is confined to the busy window
  a_r2_strobes_inside_busy: assert property (@(posedge clk) disable iff (!rstN)
    (stkWrEn || srClr || vecRdEn || pcLoad) |-> busy);

  // R2: at most one step strobe per cycle
  a_r2_one_step_at_a_time: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stkWrEn, srClr, vecRdEn, pcLoad}));

  // R3: the second push lands one word below the first
  a_r3_second_push_lower: assert property (@(posedge clk) disable iff (!rstN)
    (stkWrEn && $past(stkWrEn)) |-> (stkWrAddr == $past(stkWrAddr) - W'(2)));

  // R7: the status clear comes two cycles after the last push
  a_r7_clear_after_pushes: assert property (@(posedge clk) disable iff (!rstN)
    srClr |-> ($past(stkWrEn, 2) && !$past(stkWrEn)));

  // R8: the loaded address is the word read one cycle earlier
  a_r8_load_uses_vector: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> ($past(vecRdEn) && pcNew == $past(vecRdData) && spLoad));

  // R8: after the load the sequence ends
  a_r8_idle_after_load: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !busy);

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .instrDone (instrDone),
  .busy      (busy),
  .stkWrEn   (stkWrEn),
  .stkWrAddr (stkWrAddr),
  .srClr     (srClr),
  .vecRdEn   (vecRdEn),
  .vecRdData (vecRdData),
  .pcLoad    (pcLoad),
  .pcNew     (pcNew),
  .spLoad    (spLoad)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;

  localparam logic [31:0] MULTI = 32'hC11C_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] reqSet = '0;
  logic [31:0] swClr = '0;
  logic        instrDone = 1'b0;
  logic [15:0] srIn = '0, pcIn = '0, spIn = '0;
  logic [15:0] vecRdData;
  logic        busy, stkWrEn, srClr, vecRdEn, pcLoad, spLoad;
  logic [15:0] stkWrAddr, stkWrData, vecRdAddr, pcNew, spNew;
  logic [4:0]  ackLevel;
  logic [31:0] pendFlags;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  // vector memory model: combinational, content derived from the address
  assign vecRdData = vecRdAddr ^ 16'h1234;

  irq_entry_seq dut_i (
    .clk(clk), .rstN(rstN), .reqSet(reqSet), .swClr(swClr),
    .instrDone(instrDone), .srIn(srIn), .pcIn(pcIn), .spIn(spIn),
    .vecRdData(vecRdData), .busy(busy), .stkWrEn(stkWrEn),
    .stkWrAddr(stkWrAddr), .stkWrData(stkWrData), .srClr(srClr),
    .vecRdEn(vecRdEn), .vecRdAddr(vecRdAddr), .pcLoad(pcLoad),
    .pcNew(pcNew), .spLoad(spLoad), .spNew(spNew),
    .ackLevel(ackLevel), .pendFlags(pendFlags)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic postFlag(int lvl);
    @(negedge clk);
    reqSet = 32'd1 << lvl;
    @(negedge clk);
    reqSet = '0;
  endtask

  task automatic clearFlag(int lvl);
    @(negedge clk);
    swClr = 32'd1 << lvl;
    @(negedge clk);
    swClr = '0;
  endtask

  // drives one boundary and checks the whole entry cycle by cycle
  task automatic doEntry(int expLvl, bit gieOn, bit expTaken, int injectLvl);
    logic [15:0] sp, pc, sr, vaddr;
    sp = 16'h0400 - 16'(expLvl * 4);
    pc = 16'hC000 + 16'(expLvl * 6);
    sr = gieOn ? 16'h00F8 : 16'h00F0;
    vaddr = 16'hFFC0 + 16'(2 * expLvl);
    @(negedge clk);
    spIn = sp; pcIn = pc; srIn = sr; instrDone = 1'b1;
    @(negedge clk);
    instrDone = 1'b0;
    if (!expTaken) begin
      check("R5", "busy on refused level", {31'd0, busy}, 32'd0);
      return;
    end
    for (int cyc = 1; cyc <= 6; cyc++) begin
      check("R2", $sformatf("busy cyc%0d", cyc), {31'd0, busy}, 32'd1);
      check("R3", $sformatf("stkWrEn cyc%0d", cyc), {31'd0, stkWrEn}, {31'd0, (cyc <= 2)});
      check("R7", $sformatf("srClr cyc%0d", cyc), {31'd0, srClr}, {31'd0, (cyc == 4)});
      check("R8", $sformatf("vecRdEn cyc%0d", cyc), {31'd0, vecRdEn}, {31'd0, (cyc == 5)});
      check("R8", $sformatf("pcLoad cyc%0d", cyc), {31'd0, pcLoad}, {31'd0, (cyc == 6)});
      if (cyc == 1) begin
        check("R3", "pc push addr", {16'd0, stkWrAddr}, {16'd0, sp - 16'd2});
        check("R3", "pc push data", {16'd0, stkWrData}, {16'd0, pc});
        if (injectLvl >= 0) begin
          reqSet = 32'd1 << injectLvl;
          instrDone = 1'b1;
        end
      end
      if (cyc == 2) begin
        reqSet = '0;
        instrDone = 1'b0;
        check("R3", "sr push addr", {16'd0, stkWrAddr}, {16'd0, sp - 16'd4});
        check("R3", "sr push data", {16'd0, stkWrData}, {16'd0, sr});
      end
      if (cyc == 4) check("R4", "ackLevel", {27'd0, ackLevel}, 32'(expLvl));
      if (cyc == 5) check("R8", "vector addr", {16'd0, vecRdAddr}, {16'd0, vaddr});
      if (cyc == 6) begin
        check("R8", "pcNew", {16'd0, pcNew}, {16'd0, vaddr ^ 16'h1234});
        check("R8", "spLoad", {31'd0, spLoad}, 32'd1);
        check("R8", "spNew", {16'd0, spNew}, {16'd0, sp - 16'd4});
      end
      @(negedge clk);
    end
    check("R2", "busy after six cycles", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2", "reset busy", {31'd0, busy}, 32'd0);
    check("R6", "reset flags", pendFlags, 32'd0);
    check("R3", "reset stkWrEn", {31'd0, stkWrEn}, 32'd0);
    check("R8", "reset pcLoad", {31'd0, pcLoad}, 32'd0);

    // sweep every level with the global enable set
    for (int lvl = 0; lvl < 32; lvl++) begin
      postFlag(lvl);
      doEntry(lvl, 1'b1, 1'b1, -1);
      check("R6", $sformatf("flag after entry lvl%0d", lvl), {31'd0, pendFlags[lvl]},
            {31'd0, MULTI[lvl]});
      clearFlag(lvl);
      check("R6", $sformatf("software clear lvl%0d", lvl), pendFlags, 32'd0);
    end

    // sweep every level with the global enable clear
    for (int lvl = 0; lvl < 32; lvl++) begin
      postFlag(lvl);
      doEntry(lvl, 1'b0, (lvl >= 28), -1);
      if (lvl < 28)
        check("R5", $sformatf("refused flag kept lvl%0d", lvl), {31'd0, pendFlags[lvl]}, 32'd1);
      clearFlag(lvl);
    end

    // pairs of simultaneous requests: the higher one wins
    for (int a = 0; a < 32; a += 3) begin
      int b;
      int hi;
      b = (a * 7 + 5) % 32;
      if (b == a) continue;
      hi = (a > b) ? a : b;
      @(negedge clk);
      reqSet = (32'd1 << a) | (32'd1 << b);
      @(negedge clk);
      reqSet = '0;
      doEntry(hi, 1'b1, 1'b1, -1);
      check("R4", $sformatf("loser pending a%0d b%0d", a, b),
            {31'd0, pendFlags[(a > b) ? b : a]}, 32'd1);
      @(negedge clk);
      swClr = '1;
      @(negedge clk);
      swClr = '0;
    end

    // masked high level beside an eligible one: only the enabled one counts
    @(negedge clk);
    reqSet = (32'd1 << 27) | (32'd1 << 28);
    @(negedge clk);
    reqSet = '0;
    doEntry(28, 1'b0, 1'b1, -1);
    check("R5", "masked 27 still pending", {31'd0, pendFlags[27]}, 32'd1);
    clearFlag(27);

    // no boundary, no entry
    postFlag(12);
    srIn = 16'h0008;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R1", "no entry without boundary", {31'd0, busy}, 32'd0);
    end

    // request and boundary arriving mid-sequence are only latched
    clearFlag(12);
    postFlag(10);
    doEntry(10, 1'b1, 1'b1, 25);
    check("R9", "late request latched", pendFlags, 32'd1 << 25);
    doEntry(25, 1'b1, 1'b1, -1);
    check("R9", "late request taken next", pendFlags, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule